// File: doc/BRIEF.md
# Counter-Based Frequency and Phase Loop Controller

This block closes a digital loop around a ring oscillator whose speed follows the supply it runs from. It turns the oscillator's speed into a signed command word for the power stage that sets that supply. Once per reference period the controller measures how many oscillator rising edges occurred and subtracts that count from a programmable target ratio. The result is the frequency error. The same error is summed into a signed phase accumulator that spans many oscillator cycles, so edges lost during a supply droop are remembered and later made up. No edge-comparing phase detector is involved, and so a phase excursion of several cycles cannot slip.

The command word is an integrator. The frequency error, shifted right by a gain parameter, is added on every measured period. The phase accumulator, shifted by a second gain parameter, is added only on every tenth measured period. This keeps the two correction paths on well-separated time scales. A mode input turns the phase path off, which leaves a frequency-only lock. The command is clamped between two programmable limits. Until the first measurement arrives it holds a programmable start value.

The edge counter runs Gray-coded in the oscillator domain. A two-flop synchronizer carries it into the reference domain, where it is decoded, and the modulo difference between successive samples gives the count.

Top module: `fpl_ctrl`

## Requirements
- R1: `count_o` equals the number of `osc_clk` rising edges in one reference period, taken modulo 2^CW, so it stays correct while the free-running counter wraps (counts below 2^CW).
- R2: Reset clears `count_o`, `phase_err_o` and `meas_vld_o`. `meas_vld_o` first reads high after the fourth rising `ref_clk` edge following reset release and then stays high. While it is low, `ctrl_o` takes the value of `ctrl_start_i` one cycle later.
- R3: On each valid period, the frequency error is `ratio_n_i - count_o`, and the error shifted right arithmetically by KF_SHIFT is added to the command.
- R4: With the phase path on, each valid period adds the frequency error to `phase_err_o`. The sum saturates at -2^(PW-1) and 2^(PW-1)-1 and never wraps, which covers at least ±8 oscillator cycles.
- R5: On the 10th, 20th, 30th and later valid periods after reset, the command also receives the updated phase accumulator shifted right arithmetically by KP_SHIFT.
- R6: With `phase_en_i` low, `phase_err_o` reads zero one cycle later and no phase term reaches the command (frequency-only lock).
- R7: After every update, `ctrl_o` lies between `ctrl_min_i` and `ctrl_max_i`, with a sum above the maximum replaced by the maximum and one below the minimum replaced by the minimum.
- R8: A run-time change of `ratio_n_i` applies from the next valid period, and a closed loop settles to the new count within one edge.
- R9: After periods with too few edges, the phase accumulator goes positive and the command climbs past its pre-disturbance value. The accumulator is then worked back to near zero, so the lost cycles are restored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; all loop state runs here |
| osc_clk | input | 1 | Supply-powered ring oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| ratio_n_i | input | NW | Target edge count per reference period |
| phase_en_i | input | 1 | 1 = phase path on, 0 = frequency-only lock |
| ctrl_min_i | input | OW | Lower clamp of the command (signed) |
| ctrl_max_i | input | OW | Upper clamp of the command (signed) |
| ctrl_start_i | input | OW | Command held before the first measurement (signed) |
| count_o | output | CW | Last measured edge count |
| meas_vld_o | output | 1 | Measurement valid, high every period once primed |
| phase_err_o | output | PW | Phase accumulator in oscillator cycles (signed) |
| ctrl_o | output | OW | Command word to the power stage (signed) |

## Verification
The oscillator is driven as an exact burst of k edges inside each reference period. Sweeping k from 0 upward against several ratios shows whether counting, sign and magnitude of the error are right, and bursts near 2^CW expose a broken modulo difference. Long fixed mismatches on each side drive the phase accumulator into both saturation limits and the command onto both clamps. Holding k equal to the ratio tells a spurious drift from a true hold. In a closed loop the bench derives k from the command, then retargets the ratio and injects an edge deficit. This separates a loop that only restores frequency from one that also pays back the lost cycles.

// File: rtl/fpl_pkg.sv
`timescale 1ns/1ps
package fpl_pkg;

    // Reference cycles after reset before the first full-period count exists
    localparam int FPL_PRIME = 3;

    function automatic logic [31:0] bin2gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] gray2bin(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/fpl_osc_cnt.sv
`timescale 1ns/1ps
module fpl_osc_cnt #(
    parameter int CW = 8
) (
    input  logic          osc_clk,
    input  logic          rst_n,
    output logic [CW-1:0] gray_o
);
    typedef struct packed {
        logic [CW-1:0] bin;
        logic [CW-1:0] gray;
    } osc_st_t;

    osc_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.bin  = st_q.bin + CW'(1);
        // Registered Gray copy: exactly one bit toggles per oscillator edge
        st_d.gray = CW'(fpl_pkg::bin2gray(32'(st_d.bin)));
    end

    always_ff @(posedge osc_clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gray_o = st_q.gray;
endmodule

// File: rtl/fpl_cnt_xing.sv
`timescale 1ns/1ps
module fpl_cnt_xing #(
    parameter int CW    = 8,
    parameter int PRIME = fpl_pkg::FPL_PRIME
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] gray_i,
    output logic [CW-1:0] cnt_o,
    output logic          vld_o
);
    localparam int FW = $clog2(PRIME + 1);
    localparam logic [FW-1:0] FILL_DONE = FW'(PRIME);

    typedef struct packed {
        logic [CW-1:0] s1;
        logic [CW-1:0] s2;
        logic [CW-1:0] prev;
        logic [CW-1:0] cnt;
        logic [FW-1:0] fill;
        logic          vld;
    } xing_st_t;

    xing_st_t      st_d, st_q;
    logic [CW-1:0] dec;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = gray_i;
        st_d.s2   = st_q.s1;
        dec       = CW'(fpl_pkg::gray2bin(32'(st_q.s2)));
        st_d.prev = dec;
        st_d.cnt  = dec - st_q.prev;      // modulo 2^CW difference
        st_d.vld  = (st_q.fill == FILL_DONE);
        if (st_q.fill != FILL_DONE) st_d.fill = st_q.fill + FW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
    assign vld_o = st_q.vld;
endmodule

// File: rtl/fpl_loop_core.sv
`timescale 1ns/1ps
module fpl_loop_core #(
    parameter int NW       = 8,
    parameter int CW       = 8,
    parameter int PW       = 8,
    parameter int OW       = 12,
    parameter int KF_SHIFT = 0,
    parameter int KP_SHIFT = 2,
    parameter int PH_DIV   = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CW-1:0]        cnt_i,
    input  logic                 vld_i,
    input  logic [NW-1:0]        ratio_i,
    input  logic                 phase_en_i,
    input  logic signed [OW-1:0] ctrl_min_i,
    input  logic signed [OW-1:0] ctrl_max_i,
    input  logic signed [OW-1:0] ctrl_start_i,
    output logic signed [PW-1:0] phase_o,
    output logic signed [OW-1:0] ctrl_o
);
    localparam int EW     = ((NW > CW) ? NW : CW) + 2;
    localparam int W1     = (OW > EW) ? OW : EW;
    localparam int IW     = ((W1 > PW) ? W1 : PW) + 2;
    localparam int SW     = $clog2(PH_DIV);
    localparam int PH_MAX = (1 << (PW - 1)) - 1;
    localparam int PH_MIN = -(1 << (PW - 1));
    localparam logic [SW-1:0] SLOT_LAST = SW'(PH_DIV - 1);

    typedef struct packed {
        logic signed [PW-1:0] ph;
        logic signed [OW-1:0] ctrl;
        logic [SW-1:0]        slot;
        logic                 started;
    } loop_st_t;

    loop_st_t              st_d, st_q;
    logic signed [EW-1:0]  ferr;
    logic signed [IW-1:0]  ph_sum, ph_sat, step, base, sum, lo, hi, ctrl_nxt;
    logic                  slot_hit;

    always_comb begin
        ferr = $signed({{(EW-NW){1'b0}}, ratio_i}) - $signed({{(EW-CW){1'b0}}, cnt_i});

        ph_sum = IW'(st_q.ph) + IW'(ferr);
        if (ph_sum > IW'(PH_MAX))      ph_sat = IW'(PH_MAX);
        else if (ph_sum < IW'(PH_MIN)) ph_sat = IW'(PH_MIN);
        else                           ph_sat = ph_sum;

        slot_hit = (st_q.slot == SLOT_LAST);

        step = IW'(ferr) >>> KF_SHIFT;
        if (phase_en_i && slot_hit) step = step + (ph_sat >>> KP_SHIFT);

        base = st_q.started ? IW'(st_q.ctrl) : IW'(ctrl_start_i);
        sum  = base + step;
        lo   = IW'(ctrl_min_i);
        hi   = IW'(ctrl_max_i);
        ctrl_nxt = sum;
        if (sum > hi) ctrl_nxt = hi;
        if (sum < lo) ctrl_nxt = lo;

        st_d = st_q;
        if (vld_i) begin
            st_d.ph      = phase_en_i ? PW'(ph_sat) : '0;
            st_d.ctrl    = OW'(ctrl_nxt);
            st_d.slot    = slot_hit ? '0 : st_q.slot + SW'(1);
            st_d.started = 1'b1;
        end else begin
            if (!st_q.started) st_d.ctrl = ctrl_start_i;
            if (!phase_en_i)   st_d.ph   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign phase_o = st_q.ph;
    assign ctrl_o  = st_q.ctrl;
endmodule

// File: rtl/fpl_ctrl.sv
`timescale 1ns/1ps
module fpl_ctrl #(
    parameter int NW       = 8,
    parameter int CW       = 8,
    parameter int PW       = 8,
    parameter int OW       = 12,
    parameter int KF_SHIFT = 0,
    parameter int KP_SHIFT = 2,
    parameter int PH_DIV   = 10
) (
    input  logic                 ref_clk,
    input  logic                 osc_clk,
    input  logic                 rst_n,
    input  logic [NW-1:0]        ratio_n_i,
    input  logic                 phase_en_i,
    input  logic signed [OW-1:0] ctrl_min_i,
    input  logic signed [OW-1:0] ctrl_max_i,
    input  logic signed [OW-1:0] ctrl_start_i,
    output logic [CW-1:0]        count_o,
    output logic                 meas_vld_o,
    output logic signed [PW-1:0] phase_err_o,
    output logic signed [OW-1:0] ctrl_o
);
    logic [CW-1:0] gray_w;

    fpl_osc_cnt #(.CW(CW)) u_osc_cnt (
        .osc_clk (osc_clk),
        .rst_n   (rst_n),
        .gray_o  (gray_w)
    );

    fpl_cnt_xing #(.CW(CW), .PRIME(fpl_pkg::FPL_PRIME)) u_xing (
        .clk    (ref_clk),
        .rst_n  (rst_n),
        .gray_i (gray_w),
        .cnt_o  (count_o),
        .vld_o  (meas_vld_o)
    );

    fpl_loop_core #(
        .NW(NW), .CW(CW), .PW(PW), .OW(OW),
        .KF_SHIFT(KF_SHIFT), .KP_SHIFT(KP_SHIFT), .PH_DIV(PH_DIV)
    ) u_loop (
        .clk          (ref_clk),
        .rst_n        (rst_n),
        .cnt_i        (count_o),
        .vld_i        (meas_vld_o),
        .ratio_i      (ratio_n_i),
        .phase_en_i   (phase_en_i),
        .ctrl_min_i   (ctrl_min_i),
        .ctrl_max_i   (ctrl_max_i),
        .ctrl_start_i (ctrl_start_i),
        .phase_o      (phase_err_o),
        .ctrl_o       (ctrl_o)
    );
endmodule

// File: rtl/fpl_ctrl_chk.sv
`timescale 1ns/1ps
module fpl_ctrl_chk #(
    parameter int NW = 8,
    parameter int CW = 8,
    parameter int PW = 8,
    parameter int OW = 12
) (
    input logic                 ref_clk,
    input logic                 rst_n,
    input logic [NW-1:0]        ratio_n_i,
    input logic                 phase_en_i,
    input logic signed [OW-1:0] ctrl_min_i,
    input logic signed [OW-1:0] ctrl_max_i,
    input logic signed [OW-1:0] ctrl_start_i,
    input logic [CW-1:0]        count_o,
    input logic                 meas_vld_o,
    input logic signed [PW-1:0] phase_err_o,
    input logic signed [OW-1:0] ctrl_o
);
    AST_HOLD_START: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !meas_vld_o |=> (ctrl_o == $past(ctrl_start_i)));                        // R2
    AST_VLD_STICKY: assert property (@(posedge ref_clk) disable iff (!rst_n)
        meas_vld_o |=> meas_vld_o);                                               // R2
    AST_CTRL_LIMITS: assert property (@(posedge ref_clk) disable iff (!rst_n)
        meas_vld_o |=> (ctrl_o >= $past(ctrl_min_i) && ctrl_o <= $past(ctrl_max_i))); // R7
    AST_PHASE_NO_WRAP_UP: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (meas_vld_o && phase_en_i && (32'(ratio_n_i) > 32'(count_o)))
        |=> (phase_err_o >= $past(phase_err_o)));                                 // R4
    AST_PHASE_NO_WRAP_DN: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (meas_vld_o && phase_en_i && (32'(ratio_n_i) < 32'(count_o)))
        |=> (phase_err_o <= $past(phase_err_o)));                                 // R4
    AST_FREQ_ONLY: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !phase_en_i |=> (phase_err_o == '0));                                     // R6
    AST_LOCK_HOLD: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (meas_vld_o && !phase_en_i && (32'(ratio_n_i) == 32'(count_o))
         && ctrl_o >= ctrl_min_i && ctrl_o <= ctrl_max_i) |=> $stable(ctrl_o));   // R3
endmodule

bind fpl_ctrl fpl_ctrl_chk #(.NW(NW), .CW(CW), .PW(PW), .OW(OW)) u_chk (
    .ref_clk      (ref_clk),
    .rst_n        (rst_n),
    .ratio_n_i    (ratio_n_i),
    .phase_en_i   (phase_en_i),
    .ctrl_min_i   (ctrl_min_i),
    .ctrl_max_i   (ctrl_max_i),
    .ctrl_start_i (ctrl_start_i),
    .count_o      (count_o),
    .meas_vld_o   (meas_vld_o),
    .phase_err_o  (phase_err_o),
    .ctrl_o       (ctrl_o)
);

// File: tb/fpl_ctrl_tb.sv
`timescale 1ns/1ps
module fpl_ctrl_tb;
    localparam int REF_PERIOD = 120;
    localparam int NW = 8, CW = 8, PW = 8, OW = 12;
    localparam int KF = 0, KP = 2, PH_DIV = 10;
    localparam int PH_MAX = 127, PH_MIN = -128;

    logic                 ref_clk = 1'b0;
    logic                 osc_clk = 1'b0;
    logic                 rst_n   = 1'b0;
    logic [NW-1:0]        ratio_n_i = '0;
    logic                 phase_en_i = 1'b1;
    logic signed [OW-1:0] ctrl_min_i = '0;
    logic signed [OW-1:0] ctrl_max_i = '0;
    logic signed [OW-1:0] ctrl_start_i = '0;
    logic [CW-1:0]        count_o;
    logic                 meas_vld_o;
    logic signed [PW-1:0] phase_err_o;
    logic signed [OW-1:0] ctrl_o;

    fpl_ctrl #(.NW(NW), .CW(CW), .PW(PW), .OW(OW),
               .KF_SHIFT(KF), .KP_SHIFT(KP), .PH_DIV(PH_DIV)) u_dut (
        .ref_clk(ref_clk), .osc_clk(osc_clk), .rst_n(rst_n),
        .ratio_n_i(ratio_n_i), .phase_en_i(phase_en_i),
        .ctrl_min_i(ctrl_min_i), .ctrl_max_i(ctrl_max_i), .ctrl_start_i(ctrl_start_i),
        .count_o(count_o), .meas_vld_o(meas_vld_o),
        .phase_err_o(phase_err_o), .ctrl_o(ctrl_o)
    );

    int n_chk = 0, n_err = 0;
    int k_cur = 0, k_age = 0;
    bit closed = 0;
    int droop = 0;
    int m_ph, m_ctrl, m_slot;
    bit m_started;
    string tag = "R3";

    always #(REF_PERIOD / 2) ref_clk = ~ref_clk;

    // Exactly k_cur oscillator edges strictly inside every reference period
    initial begin
        int kk;
        forever begin
            @(posedge ref_clk);
            #1;
            kk = k_cur;
            for (int i = 0; i < kk; i++) begin
                osc_clk = 1'b1;
                #(118.0 / kk / 2.0);
                osc_clk = 1'b0;
                #(118.0 / kk / 2.0);
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int sat_ph(input int v);
        if (v > PH_MAX) return PH_MAX;
        if (v < PH_MIN) return PH_MIN;
        return v;
    endfunction

    task automatic set_k(input int k);
        k_cur = k;
        k_age = 0;
    endtask

    // Called just after a falling edge; predicts the next update, then compares
    task automatic step();
        int fe, phn, st, sum;
        bit hit;
        if (closed) begin
            k_cur = (int'(ctrl_o) >>> 3) - droop;
            if (k_cur < 0) k_cur = 0;
        end
        if (meas_vld_o && !closed && k_age >= 5)
            check("R1", int'(count_o), k_cur);
        if (meas_vld_o) begin
            fe  = int'(ratio_n_i) - int'(count_o);
            phn = phase_en_i ? sat_ph(m_ph + fe) : 0;
            hit = (m_slot == PH_DIV - 1);
            st  = (fe >>> KF) + ((phase_en_i && hit) ? (phn >>> KP) : 0);
            sum = (m_started ? m_ctrl : int'(ctrl_start_i)) + st;
            if (sum > int'(ctrl_max_i)) sum = int'(ctrl_max_i);
            if (sum < int'(ctrl_min_i)) sum = int'(ctrl_min_i);
            m_ctrl = sum;
            m_started = 1;
            m_ph = phn;
            m_slot = hit ? 0 : m_slot + 1;
        end else begin
            if (!m_started) m_ctrl = int'(ctrl_start_i);
            if (!phase_en_i) m_ph = 0;
        end
        @(posedge ref_clk);
        @(negedge ref_clk);
        k_age++;
        check(tag, int'(ctrl_o), m_ctrl);
        check("R4", int'(phase_err_o), m_ph);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        m_ph = 0; m_ctrl = 0; m_slot = 0; m_started = 0;
        @(negedge ref_clk);
        @(negedge ref_clk);
        check("R2", int'(meas_vld_o), 0);
        check("R2", int'(phase_err_o), 0);
        check("R2", int'(count_o), 0);
        rst_n = 1'b1;
    endtask

    initial begin
        #(REF_PERIOD * 200000);
        n_err++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

    initial begin
        int pre, mx_c, mx_p, dc;
        ratio_n_i = 8'd12; ctrl_min_i = 12'sd16; ctrl_max_i = 12'sd400;
        ctrl_start_i = 12'sd96; phase_en_i = 1'b1;
        set_k(12);
        do_reset();

        // R2: priming of the measurement and hold of the start value
        for (int i = 1; i <= 4; i++) begin
            step();
            check("R2", int'(meas_vld_o), (i >= 4) ? 1 : 0);
            check("R2", int'(ctrl_o), 96);
        end
        // R3: matched count leaves the command unchanged
        tag = "R3";
        run(26);
        check("R3", int'(ctrl_o), 96);

        // Slow oscillator: phase to upper saturation, command to upper clamp
        tag = "R5";
        set_k(10);
        run(120);
        check("R4", int'(phase_err_o), PH_MAX);
        check("R7", int'(ctrl_o), 400);

        // Fast oscillator: lower saturation and lower clamp
        set_k(16);
        run(150);
        check("R4", int'(phase_err_o), PH_MIN);
        check("R7", int'(ctrl_o), 16);

        // Frequency-only lock
        tag = "R6";
        phase_en_i = 1'b0;
        set_k(12);
        step();
        check("R6", int'(phase_err_o), 0);
        run(10);
        set_k(10);
        run(10);
        pre = int'(ctrl_o);
        step();
        check("R6", int'(ctrl_o) - pre, 2);
        run(10);
        phase_en_i = 1'b1;

        // Ratio retargeting over a sweep of edge counts
        tag = "R8";
        foreach (ratio_n_i[b]) begin end
        for (int n = 0; n < 3; n++) begin
            ratio_n_i = (n == 0) ? 8'd8 : (n == 1) ? 8'd12 : 8'd20;
            for (int k = 0; k <= 24; k += 2) begin
                set_k(k);
                run(8);
            end
        end

        // Counter wrap within a period
        tag = "R3";
        ratio_n_i = 8'd200;
        set_k(200);
        run(12);
        ratio_n_i = 8'd255;
        set_k(255);
        run(12);

        // Closed loop: oscillator speed follows the command
        ratio_n_i = 8'd12;
        set_k(12);
        do_reset();
        run(6);
        closed = 1;
        run(40);
        tag = "R8";
        ratio_n_i = 8'd14;
        run(250);
        dc = int'(count_o) - 14;
        check("R8", (dc >= -1 && dc <= 1) ? 1 : 0, 1);

        // Edge deficit and its repayment
        tag = "R9";
        pre = int'(ctrl_o);
        mx_c = pre; mx_p = 0;
        droop = 3;
        for (int i = 0; i < 6; i++) begin
            step();
            if (int'(ctrl_o) > mx_c) mx_c = int'(ctrl_o);
            if (int'(phase_err_o) > mx_p) mx_p = int'(phase_err_o);
        end
        droop = 0;
        for (int i = 0; i < 40; i++) begin
            step();
            if (int'(ctrl_o) > mx_c) mx_c = int'(ctrl_o);
            if (int'(phase_err_o) > mx_p) mx_p = int'(phase_err_o);
        end
        check("R9", (mx_p >= 8) ? 1 : 0, 1);
        check("R9", (mx_c > pre) ? 1 : 0, 1);
        run(250);
        check("R9", (int'(phase_err_o) >= -6 && int'(phase_err_o) <= 6) ? 1 : 0, 1);
        dc = int'(count_o) - 14;
        check("R9", (dc >= -1 && dc <= 1) ? 1 : 0, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end
endmodule